// File: doc/BRIEF.md
# Pending Bitmap Priority Scanner

This block walks two tables that live in system memory and picks the most urgent pending message-signalled interrupt. The first table is a pending bitmap with one bit per interrupt ID. The second holds one configuration byte per interrupt. On a start pulse the scanner steps through every entry that the ID-bits setting allows. It fetches each pending byte once and reads a configuration byte only for entries whose pending bit is set. It then compares the masked priority of that entry with the best candidate found so far, which starts from a priority supplied by the caller.

The scanner reaches memory through a byte-wide read port. The port carries a one-cycle request with an address, and a later valid strobe with the data. Only one read is outstanding at any time. When the scan ends, a one-cycle done pulse marks the result. The result holds the winning ID, its priority, its group and a flag that says whether any entry beat the incoming priority. These outputs then hold their values until the next accepted start.

Top module: `pend_prio_scan`

## Requirements
- R1: A start is answered with done in the very next cycle, with no memory request and the better flag low, if any of the following holds: the scan enable is low, the configuration base input is all zero, the pending base input is all zero, or the ID-bits value is below 13.
- R2: A scan covers N = 2^(idbits-1) entries. Entry i stands for interrupt ID 8192+i, and an entry index is never reported as an ID.
- R3: The pending bit for ID n is bit (n mod 8) of the byte at address {pend_base[51:16],16'h0000} + n/8. Bits [15:0] of the pending base input do not affect any address.
- R4: The configuration byte for entry i is read from cfg_base + i. It is read only when the pending bit of entry i is set.
- R5: The pending table is read exactly once per group of 8 consecutive IDs, giving N/8 pending reads per scan.
- R6: The priority of an entry is its configuration byte with bits [1:0] forced to zero, so the priority value is {cfg[7:2],2'b00}.
- R7: An entry replaces the current best only when its priority is strictly less than the best so far, which starts at cur_prio_i. On a tie the earlier candidate is kept, whether that is a lower ID or the incoming priority.
- R8: The group output is 2'b10 (non-secure group 1) when the better flag is set, and 2'b00 otherwise.
- R9: At an accepted start the result is cleared to ID 0, priority cur_prio_i and better low. Done is high for exactly one cycle, in cycle D after the start edge, and the final result is visible from that cycle on until the next accepted start. With a memory valid L cycles after each request, D = 1 + the sum over pending bytes of (1+L), plus 1 for each entry, plus L more for each pending entry.
- R10: A memory request lasts one cycle, and no new request is issued until the valid strobe of the previous one has been seen.
- R11: A start pulse that arrives while a scan is running has no effect on that scan's timing or result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Begin a scan (taken only when idle) |
| scan_en_i | input | 1 | Scanning of message interrupts enabled |
| idbits_i | input | 5 | ID-bits setting; the scan covers 2^(idbits-1) entries |
| cfg_base_i | input | 52 | Byte address of the configuration table |
| pend_base_i | input | 52 | Pending table base register; bits [51:16] form the address |
| cur_prio_i | input | 8 | Priority of the current best interrupt |
| mem_req_o | output | 1 | One-cycle memory read request |
| mem_addr_o | output | 52 | Byte address of the request |
| mem_rvalid_i | input | 1 | Read data valid |
| mem_rdata_i | input | 8 | Read data byte |
| win_id_o | output | 32 | Winning interrupt ID |
| win_prio_o | output | 8 | Winning priority |
| win_grp_o | output | 2 | Winning group (2'b10 non-secure group 1, 2'b00 none) |
| better_o | output | 1 | A pending entry beat cur_prio_i |
| done_o | output | 1 | One-cycle scan-complete pulse |

## Verification
In one cycle the scanner can both evaluate the final entry of the table and latch the scan result. This happens when the last entry is pending, because its configuration read returns in the very cycle the scan ends. The bench sets up this case by marking the final entry, and its whole last pending byte, as pending, and by giving the final entry the lowest priority in the table. The case passes only if the reported ID at done is the last ID of the table, with its masked priority. The same pattern is also run with the last entry losing, so that a stale candidate cannot slip into the result.

// File: rtl/pps_pkg.sv
package pps_pkg;

    localparam int ID_W   = 32;
    localparam int PRIO_W = 8;

    typedef logic [PRIO_W-1:0] prio_t;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_PREQ,
        ST_PWAIT,
        ST_BIT,
        ST_CWAIT,
        ST_FIN
    } scan_state_e;

    typedef enum logic [1:0] {
        GRP_NONE  = 2'b00,
        GRP_SEC1  = 2'b01,
        GRP_NSEC1 = 2'b10
    } grp_e;

    typedef struct packed {
        logic            valid;
        logic [ID_W-1:0] id;
        prio_t           prio;
    } cand_t;

    function automatic prio_t cfg_to_prio(input logic [7:0] cfg);
        return {cfg[7:2], 2'b00};
    endfunction

endpackage

// File: rtl/pps_gate.sv
module pps_gate #(
    parameter int ADDR_W     = 52,
    parameter int IDB_W      = 5,
    parameter int IDX_W      = 31,
    parameter int MIN_IDBITS = 13,
    parameter int PEND_ALIGN = 16
) (
    input  logic              scan_en,
    input  logic [IDB_W-1:0]  idbits,
    input  logic [ADDR_W-1:0] cfg_base,
    input  logic [ADDR_W-1:0] pend_base,
    output logic              skip,
    output logic [IDX_W-1:0]  last_idx,
    output logic [ADDR_W-1:0] pend_origin
);

    assign skip = !scan_en
               || (cfg_base == '0)
               || (pend_base == '0)
               || (idbits < IDB_W'(MIN_IDBITS));

    // Entry count is 2^(idbits-1); only meaningful when not skipping.
    assign last_idx = (IDX_W'(1) << (idbits - 1'b1)) - IDX_W'(1);

    generate
        if (PEND_ALIGN > 0) begin : g_align
            assign pend_origin = {pend_base[ADDR_W-1:PEND_ALIGN], {PEND_ALIGN{1'b0}}};
        end else begin : g_noalign
            assign pend_origin = pend_base;
        end
    endgenerate

endmodule

// File: rtl/pps_ctrl.sv
module pps_ctrl
    import pps_pkg::*;
#(
    parameter int ADDR_W    = 52,
    parameter int IDX_W     = 31,
    parameter int LPI_FIRST = 8192
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic              skip,
    input  logic [IDX_W-1:0]  last_idx,
    input  logic [ADDR_W-1:0] cfg_base,
    input  logic [ADDR_W-1:0] pend_origin,
    output logic              mem_req,
    output logic [ADDR_W-1:0] mem_addr,
    input  logic              mem_rvalid,
    input  logic [7:0]        mem_rdata,
    output logic              accept,
    output cand_t             cand,
    output logic              load_res,
    output logic              done
);

    scan_state_e       state_q, state_d;
    logic [IDX_W-1:0]  idx_q, idx_d, last_q;
    logic [ADDR_W-1:0] cfgb_q, pendb_q;
    logic [7:0]        pbyte_q;
    logic [ID_W-1:0]   cur_id;
    logic              at_last, byte_end, pend_bit, step;

    assign cur_id   = ID_W'(LPI_FIRST) + ID_W'(idx_q);
    assign at_last  = (idx_q == last_q);
    assign byte_end = (cur_id[2:0] == 3'd7);
    assign pend_bit = pbyte_q[cur_id[2:0]];

    always_comb begin
        state_d  = state_q;
        idx_d    = idx_q;
        mem_req  = 1'b0;
        mem_addr = '0;
        cand     = '0;
        accept   = 1'b0;
        step     = 1'b0;
        case (state_q)
            ST_IDLE: begin
                if (start) begin
                    accept  = 1'b1;
                    idx_d   = '0;
                    state_d = skip ? ST_FIN : ST_PREQ;
                end
            end
            ST_PREQ: begin
                mem_req  = 1'b1;
                mem_addr = pendb_q + ADDR_W'(cur_id >> 3);
                state_d  = ST_PWAIT;
            end
            ST_PWAIT: begin
                if (mem_rvalid) state_d = ST_BIT;
            end
            ST_BIT: begin
                if (pend_bit) begin
                    mem_req  = 1'b1;
                    mem_addr = cfgb_q + ADDR_W'(idx_q);
                    state_d  = ST_CWAIT;
                end else begin
                    step = 1'b1;
                end
            end
            ST_CWAIT: begin
                if (mem_rvalid) begin
                    cand.valid = 1'b1;
                    cand.id    = cur_id;
                    cand.prio  = cfg_to_prio(mem_rdata);
                    step       = 1'b1;
                end
            end
            ST_FIN:  state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
        if (step) begin
            if (at_last) begin
                state_d = ST_FIN;
            end else begin
                idx_d   = idx_q + IDX_W'(1);
                state_d = byte_end ? ST_PREQ : ST_BIT;
            end
        end
    end

    assign load_res = (state_d == ST_FIN) && (state_q != ST_FIN) && (state_q != ST_IDLE);
    assign done     = (state_q == ST_FIN);

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            idx_q   <= '0;
            last_q  <= '0;
            cfgb_q  <= '0;
            pendb_q <= '0;
            pbyte_q <= '0;
        end else begin
            state_q <= state_d;
            idx_q   <= idx_d;
            if (accept) begin
                last_q  <= last_idx;
                cfgb_q  <= cfg_base;
                pendb_q <= pend_origin;
            end
            if (state_q == ST_PWAIT && mem_rvalid) pbyte_q <= mem_rdata;
        end
    end

    // Outstanding-read tracker for the port assertions.
    logic wait_q;
    always_ff @(posedge clk) begin
        if (rst)             wait_q <= 1'b0;
        else if (mem_req)    wait_q <= 1'b1;
        else if (mem_rvalid) wait_q <= 1'b0;
    end

    p_one_outstanding_r10: assert property (@(posedge clk) disable iff (rst)
        mem_req |-> !wait_q);

    p_req_single_cycle_r10: assert property (@(posedge clk) disable iff (rst)
        mem_req |=> !mem_req);

    p_skip_immediate_r1: assert property (@(posedge clk) disable iff (rst)
        (accept && skip) |=> (done && !mem_req));

    p_done_pulse_r9: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    p_busy_ignores_start_r11: assert property (@(posedge clk) disable iff (rst)
        (start && state_q != ST_IDLE) |-> !accept);

endmodule

// File: rtl/pps_track.sv
module pps_track
    import pps_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic            clear,
    input  prio_t           cur_prio,
    input  cand_t           cand,
    input  logic            load,
    output logic [ID_W-1:0] res_id,
    output prio_t           res_prio,
    output logic            res_better,
    output logic [1:0]      res_grp
);

    logic [ID_W-1:0] run_id_q, run_id_d;
    prio_t           run_prio_q, run_prio_d;
    logic            run_bet_q, run_bet_d;
    logic            wins;

    assign wins = cand.valid && (cand.prio < run_prio_q);

    always_comb begin
        run_id_d   = run_id_q;
        run_prio_d = run_prio_q;
        run_bet_d  = run_bet_q;
        if (wins) begin
            run_id_d   = cand.id;
            run_prio_d = cand.prio;
            run_bet_d  = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            run_id_q   <= '0;
            run_prio_q <= '1;
            run_bet_q  <= 1'b0;
            res_id     <= '0;
            res_prio   <= '0;
            res_better <= 1'b0;
        end else if (clear) begin
            run_id_q   <= '0;
            run_prio_q <= cur_prio;
            run_bet_q  <= 1'b0;
            res_id     <= '0;
            res_prio   <= cur_prio;
            res_better <= 1'b0;
        end else begin
            run_id_q   <= run_id_d;
            run_prio_q <= run_prio_d;
            run_bet_q  <= run_bet_d;
            if (load) begin
                res_id     <= run_id_d;
                res_prio   <= run_prio_d;
                res_better <= run_bet_d;
            end
        end
    end

    assign res_grp = res_better ? GRP_NSEC1 : GRP_NONE;

    p_prio_masked_r6: assert property (@(posedge clk) disable iff (rst)
        res_better |-> (res_prio[1:0] == 2'b00));

    p_strict_lower_r7: assert property (@(posedge clk) disable iff (rst)
        (cand.valid && !clear && cand.prio >= run_prio_q) |=> (run_id_q == $past(run_id_q)));

    p_result_hold_r9: assert property (@(posedge clk) disable iff (rst)
        (!clear && !load) |=> ($stable(res_id) && $stable(res_prio) && $stable(res_better)));

endmodule

// File: rtl/pend_prio_scan.sv
module pend_prio_scan
    import pps_pkg::*;
#(
    parameter int ADDR_W     = 52,
    parameter int IDB_W      = 5,
    parameter int MIN_IDBITS = 13,
    parameter int LPI_FIRST  = 8192,
    parameter int PEND_ALIGN = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start_i,
    input  logic              scan_en_i,
    input  logic [IDB_W-1:0]  idbits_i,
    input  logic [ADDR_W-1:0] cfg_base_i,
    input  logic [ADDR_W-1:0] pend_base_i,
    input  logic [7:0]        cur_prio_i,
    output logic              mem_req_o,
    output logic [ADDR_W-1:0] mem_addr_o,
    input  logic              mem_rvalid_i,
    input  logic [7:0]        mem_rdata_i,
    output logic [31:0]       win_id_o,
    output logic [7:0]        win_prio_o,
    output logic [1:0]        win_grp_o,
    output logic              better_o,
    output logic              done_o
);

    localparam int IDX_W = (1 << IDB_W) - 1;

    logic              skip;
    logic [IDX_W-1:0]  last_idx;
    logic [ADDR_W-1:0] pend_origin;
    logic              accept, load_res;
    cand_t             cand;
    logic [ID_W-1:0]   res_id;
    prio_t             res_prio;

    pps_gate #(
        .ADDR_W(ADDR_W), .IDB_W(IDB_W), .IDX_W(IDX_W),
        .MIN_IDBITS(MIN_IDBITS), .PEND_ALIGN(PEND_ALIGN)
    ) gate_i (
        .scan_en     (scan_en_i),
        .idbits      (idbits_i),
        .cfg_base    (cfg_base_i),
        .pend_base   (pend_base_i),
        .skip        (skip),
        .last_idx    (last_idx),
        .pend_origin (pend_origin)
    );

    pps_ctrl #(
        .ADDR_W(ADDR_W), .IDX_W(IDX_W), .LPI_FIRST(LPI_FIRST)
    ) ctrl_i (
        .clk         (clk),
        .rst         (rst),
        .start       (start_i),
        .skip        (skip),
        .last_idx    (last_idx),
        .cfg_base    (cfg_base_i),
        .pend_origin (pend_origin),
        .mem_req     (mem_req_o),
        .mem_addr    (mem_addr_o),
        .mem_rvalid  (mem_rvalid_i),
        .mem_rdata   (mem_rdata_i),
        .accept      (accept),
        .cand        (cand),
        .load_res    (load_res),
        .done        (done_o)
    );

    pps_track track_i (
        .clk        (clk),
        .rst        (rst),
        .clear      (accept),
        .cur_prio   (cur_prio_i),
        .cand       (cand),
        .load       (load_res),
        .res_id     (res_id),
        .res_prio   (res_prio),
        .res_better (better_o),
        .res_grp    (win_grp_o)
    );

    assign win_id_o   = res_id;
    assign win_prio_o = res_prio;

endmodule

// File: tb/pend_prio_scan_tb.sv
module pend_prio_scan_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int AW = 52;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          start = 1'b0;
    logic          scan_en = 1'b0;
    logic [4:0]    idbits = '0;
    logic [AW-1:0] cfg_base = '0;
    logic [AW-1:0] pend_base = '0;
    logic [7:0]    cur_prio = '0;
    logic          mem_req;
    logic [AW-1:0] mem_addr;
    logic          mem_rvalid;
    logic [7:0]    mem_rdata;
    logic [31:0]   win_id;
    logic [7:0]    win_prio;
    logic [1:0]    win_grp;
    logic          better;
    logic          done;

    always #(CLK_PERIOD/2) clk = ~clk;

    pend_prio_scan dut_i (
        .clk(clk), .rst(rst), .start_i(start), .scan_en_i(scan_en),
        .idbits_i(idbits), .cfg_base_i(cfg_base), .pend_base_i(pend_base),
        .cur_prio_i(cur_prio), .mem_req_o(mem_req), .mem_addr_o(mem_addr),
        .mem_rvalid_i(mem_rvalid), .mem_rdata_i(mem_rdata),
        .win_id_o(win_id), .win_prio_o(win_prio), .win_grp_o(win_grp),
        .better_o(better), .done_o(done)
    );

    int checks = 0;
    int errors = 0;

    // Behavioural memory with fixed latency.
    logic [7:0] mem [longint];
    int         lat = 1;
    int         cnt = 0;
    logic [7:0] rdq = '0;
    longint     cb_m = 0, pb_m = 0;
    int         n_m = 0;
    int         n_cfg = 0, n_pend = 0, n_stray = 0;

    function automatic logic [7:0] rd(input longint a);
        if (mem.exists(a)) return mem[a];
        return 8'h00;
    endfunction

    function automatic bit pend_of(input longint i);
        longint id;
        logic [7:0] b;
        id = 64'd8192 + i;
        b  = rd(pb_m + id / 8);
        return b[id % 8];
    endfunction

    task automatic check(input string r, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", r, act, exp);
        end
    endtask

    assign mem_rvalid = (cnt == 1);
    assign mem_rdata  = rdq;

    always @(posedge clk) begin
        if (rst) begin
            cnt <= 0;
        end else if (mem_req) begin
            longint a;
            a = longint'(mem_addr);
            checks++;
            if (cnt != 0) begin
                errors++;
                $display("FAIL R10 request while busy actual=%0d expected=0", cnt);
            end
            cnt <= lat;
            rdq <= rd(a);
            if (a >= cb_m && a < cb_m + n_m) begin
                n_cfg++;
                checks++;
                if (!pend_of(a - cb_m)) begin
                    errors++;
                    $display("FAIL R4 config read of idle entry actual=%0h expected=pending", a);
                end
            end else if (a >= pb_m + 1024 && a < pb_m + 1024 + n_m / 8) begin
                n_pend++;
            end else begin
                n_stray++;
            end
        end else if (cnt != 0) begin
            cnt <= cnt - 1;
        end
    end

    task automatic run_scan(input bit en, input int idb, input logic [AW-1:0] cb,
                            input logic [AW-1:0] pb, input logic [7:0] cur,
                            input int l, input int stray_k, input string tag);
        bit          skip;
        int          d, ecfg, epend, n;
        logic [31:0] fid;
        logic [7:0]  fprio, best, p;
        bit          fbet;
        skip  = !en || (cb == '0) || (pb == '0) || (idb < 13);
        n     = skip ? 0 : (1 << (idb - 1));
        cb_m  = longint'(cb);
        pb_m  = longint'({pb[AW-1:16], 16'h0000});
        n_m   = n;
        lat   = l;
        n_cfg = 0; n_pend = 0; n_stray = 0;
        fid = '0; fprio = cur; fbet = 1'b0; best = cur;
        d = 1; ecfg = 0; epend = n / 8;
        for (int b = 0; b < n / 8; b++) begin
            d += 1 + l;
            for (int j = 0; j < 8; j++) begin
                int i;
                i = b * 8 + j;
                if (pend_of(i)) begin
                    d += 1 + l;
                    ecfg++;
                    p = rd(cb_m + i) & 8'hFC;
                    if (p < best) begin
                        best = p; fprio = p; fid = 32'(8192 + i); fbet = 1'b1;
                    end
                end else begin
                    d += 1;
                end
            end
        end
        @(negedge clk);
        scan_en = en; idbits = 5'(idb); cfg_base = cb; pend_base = pb; cur_prio = cur;
        start = 1'b1;
        @(posedge clk);
        for (int k = 1; k <= d + 2; k++) begin
            @(negedge clk);
            start = (k == stray_k);
            check("R9 done timing", done, (k == d));
            if (k >= d) begin
                check({tag, " R9 id"},     win_id,   fid);
                check({tag, " R9 prio"},   win_prio, fprio);
                check({tag, " R9 better"}, better,   fbet);
                check({tag, " R8 group"},  win_grp,  fbet ? 2'b10 : 2'b00);
            end else begin
                check("R9 cleared id",     win_id,   32'd0);
                check("R9 cleared prio",   win_prio, cur);
                check("R9 cleared better", better,   1'b0);
                check("R8 cleared group",  win_grp,  2'b00);
            end
        end
        start = 1'b0;
        check({tag, " R4 config reads"},  n_cfg,   ecfg);
        check({tag, " R5 pending reads"}, n_pend,  epend);
        check({tag, " R1 R3 stray reads"}, n_stray, 0);
    endtask

    localparam logic [AW-1:0] CB = 52'h0_0000_4000_0000;
    localparam logic [AW-1:0] PB = 52'h0_0008_0000_1234;
    localparam longint PBA = 64'h8_0000_0000;

    task automatic set_pend(input int i);
        longint a;
        logic [7:0] v;
        a = PBA + (8192 + i) / 8;
        v = rd(a);
        v[(8192 + i) % 8] = 1'b1;
        mem[a] = v;
    endtask

    task automatic set_cfg(input int i, input logic [7:0] v);
        mem[longint'(CB) + i] = v;
    endtask

    task automatic fill_main;
        mem.delete();
        set_pend(3);    set_cfg(3, 8'h83);
        set_pend(10);   set_cfg(10, 8'h41);
        set_pend(11);   set_cfg(11, 8'h42);
        set_pend(2000); set_cfg(2000, 8'h9F);
        set_cfg(5, 8'h00);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check("R9 reset done",   done,    1'b0);
        check("R10 reset req",   mem_req, 1'b0);
        check("R9 reset better", better,  1'b0);
        check("R9 reset id",     win_id,  32'd0);
        rst = 1'b0;

        fill_main();
        run_scan(1'b0, 13, CB, PB, 8'hF0, 1, 0, "R1 disabled");
        run_scan(1'b1, 13, CB, '0, 8'hF0, 1, 0, "R1 zero pend base");
        run_scan(1'b1, 13, '0, PB, 8'hF0, 1, 0, "R1 zero cfg base");
        run_scan(1'b1, 12, CB, PB, 8'hF0, 1, 0, "R1 idbits low");

        // Main pattern: tie at 10/11 keeps 10; idle entry 5 with prio 0 ignored.
        run_scan(1'b1, 13, CB, PB, 8'hF0, 1, 0, "R2 R3 R4 R7 main");
        check("R2 R7 main winner id", win_id, 32'd8202);

        // Masking lets 0x43 beat 0x41.
        mem.delete();
        set_pend(7); set_cfg(7, 8'h43);
        run_scan(1'b1, 13, CB, PB, 8'h41, 3, 0, "R6 mask");
        check("R6 masked prio", win_prio, 8'h40);

        // Ties with the incoming priority never win.
        mem.delete();
        set_pend(0);  set_cfg(0, 8'h40);
        set_pend(64); set_cfg(64, 8'h51);
        run_scan(1'b1, 13, CB, PB, 8'h40, 3, 0, "R7 tie incoming");

        // Last entry wins in the cycle the scan ends.
        mem.delete();
        set_pend(100); set_cfg(100, 8'h20);
        for (int i = 8184; i < 8192; i++) begin
            set_pend(i); set_cfg(i, 8'hFF);
        end
        set_cfg(8191, 8'h10);
        run_scan(1'b1, 14, CB, PB, 8'hF0, 2, 0, "R2 R5 last wins");
        check("R2 last id", win_id, 32'd16383);

        // Last entry loses.
        set_cfg(8191, 8'h30);
        run_scan(1'b1, 14, CB, PB, 8'hF0, 2, 0, "R7 last loses");
        check("R7 earlier kept", win_id, 32'd8292);

        // Stray start mid-scan.
        fill_main();
        run_scan(1'b1, 13, CB, PB, 8'hF0, 1, 300, "R11 busy start");
        check("R11 result intact", win_id, 32'd8202);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog actual=hung expected=finished");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule